// File: doc/BRIEF.md
# Ping-Pong Bulk-IN Transmit Buffer Controller

This block sits between a processor and a serial-bus protocol engine on the send path of a bulk IN endpoint. It holds two equal byte banks. The processor fills the bank it can see and then commits it. A commit marks that bank ready to send and, at once, switches the processor's view to the other bank. The bus side reads the committed bank byte by byte. It reports the outcome of the transfer with an ACK or a NACK pulse. A NACK rewinds the same bank for a resend. An ACK frees the bank and moves the bus side to the other bank if that bank is already committed.

A bank that the processor sees only becomes writable again after its earlier packet has been acknowledged. Writes aimed at a locked or full bank are discarded and raise a sticky overrun flag. A commit sends a packet whose length is the number of bytes written, so a short packet or a zero-length packet is possible. One interrupt line reports two events: an acknowledged packet that was flagged as last, and an unmasked NACK. The processor clears the line with a one-cycle acknowledge pulse.

Top module: `pingpong_tx_buf`

## Requirements
- R1: A synchronous reset empties and unlocks both banks, shows bank 0 to the processor (`cpu_vis_sel`=0, `cpu_wr_ok`=1), returns the bus side to idle (`tx_ready`=0) and clears `irq` and `cpu_overrun`.
- R2: A committed bank presents `tx_len` equal to the bytes written. After a `pkt_start` pulse, `rd_data` shows byte 0. Each `rd_en` pulse then advances to the next byte in the order the bytes were written.
- R3: A commit of an unlocked visible bank inverts `cpu_vis_sel` on the following cycle. If the bus side is idle, it also starts sending that bank in the same cycle (`tx_ready`=1, `tx_sel` = committed bank).
- R4: While the visible bank is locked, `cpu_wr_ok` is 0. A write is discarded and sets `cpu_overrun`, which stays set until reset.
- R5: Once the visible bank holds DEPTH bytes, `cpu_wr_ok` is 0. A further write is discarded and sets `cpu_overrun`.
- R6: `hs_ack` empties and unlocks the bank being sent. If that bank is the visible one, `cpu_wr_ok` returns to 1.
- R7: On `hs_ack`, if the other bank is already committed, sending moves to it in the next cycle without any processor action.
- R8: `hs_nack` keeps the same bank, length and lock, and rewinds the read position to byte 0.
- R9: A commit with no bytes written presents a zero-length packet (`tx_len`=0, `tx_ready`=1).
- R10: `irq` rises only on `hs_ack` of a packet whose commit had `cpu_last`=1. Acknowledging any other packet leaves `irq` unchanged.
- R11: `hs_nack` raises `irq` when `nack_irq_mask`=0. It does not raise `irq` when `nack_irq_mask`=1.
- R12: An `irq_ack` pulse clears `irq`. If a new event occurs in the same cycle, the event wins.
- R13: A commit while the visible bank is locked is ignored: `cpu_vis_sel` and the bus side are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_en | input | 1 | Byte write strobe into the visible bank |
| cpu_wr_data | input | DW | Write byte |
| cpu_commit | input | 1 | Commit the visible bank for sending |
| cpu_last | input | 1 | Sampled with commit: packet ends the transfer |
| nack_irq_mask | input | 1 | 1 keeps NACK from raising the interrupt |
| irq_ack | input | 1 | Clears the interrupt |
| cpu_wr_ok | output | 1 | Visible bank accepts a write |
| cpu_vis_sel | output | 1 | Bank index the processor sees |
| cpu_overrun | output | 1 | Sticky: a write was discarded |
| irq | output | 1 | Interrupt request |
| tx_ready | output | 1 | A packet is being offered to the bus side |
| tx_sel | output | 1 | Bank index being sent |
| tx_len | output | $clog2(DEPTH+1) | Packet length in bytes |
| pkt_start | input | 1 | Bus side begins (or restarts) reading a packet |
| rd_en | input | 1 | Advance to the next byte |
| rd_data | output | DW | Byte at the read position |
| hs_ack | input | 1 | Packet delivered |
| hs_nack | input | 1 | Packet must be resent |

## Verification
The bench builds the block with DEPTH=8 and DW=8. An eight-byte bank makes the full-bank boundary of R5 reachable in a few writes. It also lets every byte of a full packet be read back and compared, including after a NACK replay. The small size leaves room to run the interleaved commit, ACK and NACK sequences across both banks, as well as the zero-length and masked-NACK cases.

// File: rtl/pptx_pkg.sv
package pptx_pkg;

    // Index of the two ping-pong banks.
    localparam int NUM_BANKS = 2;

    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_e;

endpackage

// File: rtl/pptx_bank.sv
module pptx_bank #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pptx_ctrl.sv
module pptx_ctrl
    import pptx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 commit,
    input  logic                 last,
    input  logic                 nack_mask,
    input  logic                 irq_ack,
    input  logic                 pkt_start,
    input  logic                 rd_en,
    input  logic                 hs_ack,
    input  logic                 hs_nack,
    output logic                 wr_ok,
    output logic                 vis,
    output logic                 overrun,
    output logic                 irq,
    output logic                 tx_ready,
    output logic                 tx_sel,
    output logic [CW-1:0]        tx_len,
    output logic [AW-1:0]        rd_addr,
    output logic [AW-1:0]        wr_addr,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic [NUM_BANKS-1:0] lock
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [NUM_BANKS-1:0][CW-1:0] cnt;
        logic [NUM_BANKS-1:0]         lock;
        logic [NUM_BANKS-1:0]         last;
        logic                         vis;
        logic                         busy;
        logic                         sel;
        logic [CW-1:0]                ptr;
        logic                         ovr;
        logic                         irq;
    } st_t;

    st_t s_d, s_q;
    logic vis_ok;

    always_comb begin
        s_d     = s_q;
        bank_we = '0;
        vis_ok  = !s_q.lock[s_q.vis] && (s_q.cnt[s_q.vis] != FULL);

        // interrupt clear first so that a new event wins
        if (irq_ack) begin
            s_d.irq = 1'b0;
        end

        // bus side sequencing
        if (s_q.busy) begin
            if (pkt_start) begin
                s_d.ptr = '0;
            end else if (rd_en && (s_q.ptr < s_q.cnt[s_q.sel])) begin
                s_d.ptr = s_q.ptr + 1'b1;
            end

            if (hs_ack) begin
                s_d.lock[s_q.sel] = 1'b0;
                s_d.cnt[s_q.sel]  = '0;
                s_d.last[s_q.sel] = 1'b0;
                if (s_q.last[s_q.sel]) begin
                    s_d.irq = 1'b1;
                end
                if (s_q.lock[~s_q.sel]) begin
                    s_d.sel = ~s_q.sel;
                    s_d.ptr = '0;
                end else begin
                    s_d.busy = 1'b0;
                end
            end else if (hs_nack) begin
                s_d.ptr = '0;
                if (!nack_mask) begin
                    s_d.irq = 1'b1;
                end
            end
        end

        // processor side: write before commit so a same-cycle byte is included
        if (wr_en) begin
            if (vis_ok) begin
                bank_we[s_q.vis] = 1'b1;
                s_d.cnt[s_q.vis] = s_q.cnt[s_q.vis] + 1'b1;
            end else begin
                s_d.ovr = 1'b1;
            end
        end

        if (commit && !s_q.lock[s_q.vis]) begin
            s_d.lock[s_q.vis] = 1'b1;
            s_d.last[s_q.vis] = last;
            s_d.vis           = ~s_q.vis;
            if (!s_d.busy) begin
                s_d.busy = 1'b1;
                s_d.sel  = s_q.vis;
                s_d.ptr  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_ok    = vis_ok;
    assign vis      = s_q.vis;
    assign overrun  = s_q.ovr;
    assign irq      = s_q.irq;
    assign tx_ready = s_q.busy;
    assign tx_sel   = s_q.sel;
    assign tx_len   = s_q.cnt[s_q.sel];
    assign rd_addr  = s_q.ptr[AW-1:0];
    assign wr_addr  = s_q.cnt[s_q.vis][AW-1:0];
    assign lock     = s_q.lock;

endmodule

// File: rtl/pingpong_tx_buf.sv
module pingpong_tx_buf
    import pptx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_wr_en,
    input  logic [DW-1:0] cpu_wr_data,
    input  logic          cpu_commit,
    input  logic          cpu_last,
    input  logic          nack_irq_mask,
    input  logic          irq_ack,
    output logic          cpu_wr_ok,
    output logic          cpu_vis_sel,
    output logic          cpu_overrun,
    output logic          irq,
    output logic          tx_ready,
    output logic          tx_sel,
    output logic [CW-1:0] tx_len,
    input  logic          pkt_start,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          hs_ack,
    input  logic          hs_nack
);

    logic [AW-1:0]        rd_addr;
    logic [AW-1:0]        wr_addr;
    logic [NUM_BANKS-1:0] bank_we;
    logic [NUM_BANKS-1:0] lock_vec;
    logic [DW-1:0]        bank_rdata [NUM_BANKS];

    pptx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cpu_wr_en),
        .commit    (cpu_commit),
        .last      (cpu_last),
        .nack_mask (nack_irq_mask),
        .irq_ack   (irq_ack),
        .pkt_start (pkt_start),
        .rd_en     (rd_en),
        .hs_ack    (hs_ack),
        .hs_nack   (hs_nack),
        .wr_ok     (cpu_wr_ok),
        .vis       (cpu_vis_sel),
        .overrun   (cpu_overrun),
        .irq       (irq),
        .tx_ready  (tx_ready),
        .tx_sel    (tx_sel),
        .tx_len    (tx_len),
        .rd_addr   (rd_addr),
        .wr_addr   (wr_addr),
        .bank_we   (bank_we),
        .lock      (lock_vec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pptx_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .waddr (wr_addr),
            .wdata (cpu_wr_data),
            .raddr (rd_addr),
            .rdata (bank_rdata[b])
        );
    end

    assign rd_data = bank_rdata[tx_sel];

endmodule

// File: rtl/pptx_checker.sv
module pptx_checker #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_commit,
    input logic          cpu_vis_sel,
    input logic          hs_ack,
    input logic          hs_nack,
    input logic          nack_irq_mask,
    input logic          irq,
    input logic          tx_ready,
    input logic          tx_sel,
    input logic [CW-1:0] tx_len,
    input logic [1:0]    lock
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!tx_ready && !irq && !cpu_vis_sel));

    p_commit_swap_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_commit && !lock[cpu_vis_sel]) |=> (cpu_vis_sel != $past(cpu_vis_sel)));

    p_locked_commit_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (cpu_commit && lock[cpu_vis_sel]) |=> $stable(cpu_vis_sel));

    p_sent_bank_locked_r6: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> lock[tx_sel]);

    p_nack_replay_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && hs_nack && !hs_ack) |=> (tx_ready && $stable(tx_sel) && $stable(tx_len)));

    p_ack_advance_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && hs_ack && lock[~tx_sel]) |=> (tx_ready && (tx_sel != $past(tx_sel))));

    p_masked_nack_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && hs_nack && !hs_ack && nack_irq_mask && !irq) |=> !irq);

endmodule

bind pingpong_tx_buf pptx_checker #(.CW(CW)) u_pptx_checker (
    .clk           (clk),
    .rst           (rst),
    .cpu_commit    (cpu_commit),
    .cpu_vis_sel   (cpu_vis_sel),
    .hs_ack        (hs_ack),
    .hs_nack       (hs_nack),
    .nack_irq_mask (nack_irq_mask),
    .irq           (irq),
    .tx_ready      (tx_ready),
    .tx_sel        (tx_sel),
    .tx_len        (tx_len),
    .lock          (lock_vec)
);

// File: tb/test_pingpong_tx_buf.sv
`timescale 1ns/1ps
module test_pingpong_tx_buf;

    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    // ops: 1 write, 2 commit, 3 commit-last, 4 ack, 5 nack, 7 irq_ack
    // row: op[19:17] data[16:9] vis[8] wr_ok[7] ready[6] sel[5] len[4:1] irq[0]
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {3'd1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
        {3'd1, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
        {3'd1, 8'h33, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
        {3'd2, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 1'b0},
        {3'd1, 8'h44, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 1'b0},
        {3'd3, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b0},
        {3'd1, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b0},
        {3'd4, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 1'b0},
        {3'd5, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 1'b1},
        {3'd7, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 1'b0},
        {3'd4, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1},
        {3'd7, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_wr_en = 1'b0;
    logic [DW-1:0] cpu_wr_data = '0;
    logic          cpu_commit = 1'b0;
    logic          cpu_last = 1'b0;
    logic          nack_irq_mask = 1'b0;
    logic          irq_ack = 1'b0;
    logic          cpu_wr_ok, cpu_vis_sel, cpu_overrun, irq;
    logic          tx_ready, tx_sel;
    logic [CW-1:0] tx_len;
    logic          pkt_start = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          hs_ack = 1'b0;
    logic          hs_nack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pingpong_tx_buf #(.DEPTH(DEPTH), .DW(DW)) i_pingpong_tx_buf (
        .clk(clk), .rst(rst),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_commit(cpu_commit), .cpu_last(cpu_last),
        .nack_irq_mask(nack_irq_mask), .irq_ack(irq_ack),
        .cpu_wr_ok(cpu_wr_ok), .cpu_vis_sel(cpu_vis_sel),
        .cpu_overrun(cpu_overrun), .irq(irq),
        .tx_ready(tx_ready), .tx_sel(tx_sel), .tx_len(tx_len),
        .pkt_start(pkt_start), .rd_en(rd_en), .rd_data(rd_data),
        .hs_ack(hs_ack), .hs_nack(hs_nack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one op for one cycle; outputs are read at the next falling edge
    task automatic do_op(input int op, input logic [DW-1:0] data);
        cpu_wr_en   = (op == 1);
        cpu_wr_data = data;
        cpu_commit  = (op == 2) || (op == 3);
        cpu_last    = (op == 3);
        hs_ack      = (op == 4);
        hs_nack     = (op == 5);
        pkt_start   = (op == 6);
        irq_ack     = (op == 7);
        rd_en       = (op == 8);
        @(negedge clk);
        cpu_wr_en = 1'b0; cpu_commit = 1'b0; cpu_last = 1'b0;
        hs_ack = 1'b0; hs_nack = 1'b0; pkt_start = 1'b0;
        irq_ack = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        nack_irq_mask = 1'b0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 vis", 32'(cpu_vis_sel), 0);
        check("R1 wr_ok", 32'(cpu_wr_ok), 1);
        check("R1 ready", 32'(tx_ready), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 overrun", 32'(cpu_overrun), 0);

        // table walk: alternating banks, pending advance, NACK, last-packet IRQ
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            do_op(int'(v[19:17]), v[16:9]);
            check("R3 vis", 32'(cpu_vis_sel), 32'(v[8]));
            check("R6 wr_ok", 32'(cpu_wr_ok), 32'(v[7]));
            check("R7 ready", 32'(tx_ready), 32'(v[6]));
            if (v[6]) begin
                check("R7 sel", 32'(tx_sel), 32'(v[5]));
                check("R2 len", 32'(tx_len), 32'(v[4:1]));
            end
            check("R10 irq", 32'(irq), 32'(v[0]));
        end
        check("R4 overrun after locked write", 32'(cpu_overrun), 1);

        // full bank, byte order, NACK replay, last ACK interrupt
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            do_op(1, 8'hA0 + 8'(i));
            if (i == DEPTH - 2) check("R5 wr_ok before full", 32'(cpu_wr_ok), 1);
        end
        check("R5 wr_ok when full", 32'(cpu_wr_ok), 0);
        check("R5 no overrun yet", 32'(cpu_overrun), 0);
        do_op(1, 8'hFF);
        check("R5 overrun on full", 32'(cpu_overrun), 1);
        do_op(3, 8'h00);
        check("R2 len full", 32'(tx_len), DEPTH);
        do_op(6, 8'h00);
        for (int i = 0; i < DEPTH; i++) begin
            check("R2 rd_data", 32'(rd_data), 32'(8'hA0 + 8'(i)));
            do_op(8, 8'h00);
        end
        do_op(5, 8'h00);
        check("R8 ready after nack", 32'(tx_ready), 1);
        check("R8 len after nack", 32'(tx_len), DEPTH);
        do_op(6, 8'h00);
        check("R8 replay byte0", 32'(rd_data), 32'hA0);
        do_op(8, 8'h00);
        check("R8 replay byte1", 32'(rd_data), 32'hA1);
        do_op(7, 8'h00);
        do_op(4, 8'h00);
        check("R10 irq on last ack", 32'(irq), 1);
        check("R6 ready cleared", 32'(tx_ready), 0);

        // zero-length packet
        do_reset();
        do_op(2, 8'h00);
        check("R9 ready", 32'(tx_ready), 1);
        check("R9 len zero", 32'(tx_len), 0);
        do_op(4, 8'h00);
        check("R10 no irq on plain ack", 32'(irq), 0);

        // NACK mask and irq_ack
        do_reset();
        nack_irq_mask = 1'b1;
        do_op(1, 8'h5A);
        do_op(2, 8'h00);
        do_op(5, 8'h00);
        check("R11 masked nack", 32'(irq), 0);
        check("R8 sel kept", 32'(tx_sel), 0);
        nack_irq_mask = 1'b0;
        do_op(5, 8'h00);
        check("R11 unmasked nack", 32'(irq), 1);
        do_op(7, 8'h00);
        check("R12 irq_ack clears", 32'(irq), 0);
        do_op(4, 8'h00);
        check("R10 no irq plain ack", 32'(irq), 0);

        // commit while visible bank locked
        do_reset();
        do_op(2, 8'h00);
        do_op(2, 8'h00);
        check("R4 wr_ok locked", 32'(cpu_wr_ok), 0);
        check("R13 vis before", 32'(cpu_vis_sel), 0);
        do_op(2, 8'h00);
        check("R13 vis unchanged", 32'(cpu_vis_sel), 0);
        check("R13 sel unchanged", 32'(tx_sel), 0);
        do_op(4, 8'h00);
        check("R7 advance sel", 32'(tx_sel), 1);
        check("R7 advance ready", 32'(tx_ready), 1);
        do_op(4, 8'h00);
        check("R6 idle after both", 32'(tx_ready), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule